// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block produces all of the housekeeping strobe traffic that an asynchronous DRAM needs. After reset it waits out the mandatory power-up pause and then issues a burst of dummy refresh cycles. Only after that burst does it declare the memory usable. From then on it issues one refresh cycle per fixed interval for the life of the part.

Every refresh is a column-before-row cycle. The memory keeps its own row pointer, so the block carries no refresh address. The block shares the strobe pins with an access controller through a request/grant pair. `req_o` rises when refresh work is owed. A cycle starts only on an edge where `grant_i` is also high. The block then drives the strobes until the cycle's precharge is over, and it keeps `req_o` high until that point. The access controller must leave the strobes alone while `req_o` is high after a grant.

If refreshes cannot be granted on time, they are counted as owed, up to a parameterised limit. The owed refreshes are then issued back to back once grant returns. When the access controller reports a long stretch without row activity, the block withdraws `init_done_o` and repeats the dummy burst. All timing parameters are given in clock cycles. The defaults suit a 125 MHz clock: a 500 µs pause, 15.6 µs spacing, a 64 ns row pulse and a 40 ns precharge.

Top module: `dref_refresh_seq`

## Requirements
- R1: While reset is asserted, `req_o`=0, `ras_n_o`=1, every bit of `cas_n_o`=1, `we_n_o`=1, `init_done_o`=0 and `refresh_count_o`=0.
- R2: After reset is released, `req_o` stays 0 and all strobes stay high for PAUSE_CYC clock edges. `req_o` is 1 after edge PAUSE_CYC+1.
- R3: After the pause, exactly INIT_CYCLES refresh cycles are issued before `init_done_o` rises. At that moment `refresh_count_o` equals INIT_CYCLES.
- R4: In every refresh cycle, all column strobes are low for exactly CAS_LEAD cycles before the row strobe falls. The row strobe is never low unless all column strobes are low. `we_n_o` is always 1.
- R5: The row strobe stays low for exactly RAS_CYC cycles. Between two row pulses it stays high for at least PRE_CYC+CAS_LEAD+1 cycles.
- R6: While grant stays high after initialisation, consecutive row strobe falls are exactly REFI_CYC cycles apart.
- R7: No cycle starts while `grant_i` is low. A started cycle runs to completion even if `grant_i` drops. `req_o` stays 1 until that cycle's precharge ends.
- R8: While grant is withheld, owed refreshes accumulate up to MAX_POSTPONE and further intervals are dropped. When grant returns, the owed refreshes are issued back to back, with row falls CAS_LEAD+RAS_CYC+PRE_CYC+1 cycles apart.
- R9: A one-cycle pulse on `long_idle_i` after initialisation drops `init_done_o` on the next cycle. `init_done_o` then rises again after exactly INIT_CYCLES further refresh cycles.
- R10: `refresh_count_o` increases by one on each row strobe rise, wrapping modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | Access controller yields the strobes |
| long_idle_i | input | 1 | Access controller saw no row activity for longer than the retention period |
| req_o | output | 1 | Refresh work owed or a refresh cycle in progress |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | CAS_LANES | Column strobes, active low, all lanes identical |
| we_n_o | output | 1 | Write enable, held high |
| init_done_o | output | 1 | Memory initialised and available for accesses |
| refresh_count_o | output | CNT_W | Number of row pulses issued, wrapping |

## Verification
A wrong phase or pause counter shows up in `req_o` at the pause boundary within one cycle. A corrupt cycle-state counter makes a row pulse of the wrong width or breaks the column-before-row order in the very cycle that follows. A faulty interval timer or owed-refresh counter shows as a gap between row falls that is off by one or more, or as a wrong number of back-to-back cycles after grant returns. Each of these is visible by the next row strobe fall. A lost burst counter shows as an initialisation that does not take exactly eight pulses.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } dref_phase_t;

  typedef enum logic [1:0] {
    CY_IDLE = 2'd0,
    CY_CAS  = 2'd1,
    CY_RAS  = 2'd2,
    CY_PRE  = 2'd3
  } dref_cyc_t;
endpackage

// File: rtl/dref_pacer.sv
module dref_pacer
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC    = 62500,
  parameter int INIT_CYCLES  = 8,
  parameter int REFI_CYC     = 1950,
  parameter int MAX_POSTPONE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        cyc_idle_i,
  input  logic        long_idle_i,
  output logic        want_o,
  output logic        init_done_o,
  output dref_phase_t phase_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int QW = $clog2(MAX_POSTPONE + 1);

  dref_phase_t   phase;
  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] burst_left;
  logic [TW-1:0] refi_cnt;
  logic [QW-1:0] pending;
  logic          expire;
  logic          add_one;

  assign expire  = (refi_cnt == '0);
  assign add_one = expire && !start_i && (pending < QW'(MAX_POSTPONE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_PAUSE;
      pause_cnt  <= PW'(PAUSE_CYC - 1);
      burst_left <= '0;
      refi_cnt   <= TW'(REFI_CYC - 2);
      pending    <= '0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          if (pause_cnt == '0) begin
            phase      <= PH_INIT;
            burst_left <= IW'(INIT_CYCLES);
          end else begin
            pause_cnt <= pause_cnt - 1'b1;
          end
        end
        PH_INIT: begin
          if (start_i) begin
            burst_left <= burst_left - 1'b1;
            refi_cnt   <= TW'(REFI_CYC - 2);
          end else if ((burst_left == '0) && cyc_idle_i) begin
            phase <= PH_RUN;
          end
        end
        default: begin
          if (long_idle_i) begin
            phase      <= PH_INIT;
            burst_left <= IW'(INIT_CYCLES);
            pending    <= '0;
          end else begin
            if (start_i)      refi_cnt <= TW'(REFI_CYC - 2);
            else if (expire)  refi_cnt <= TW'(REFI_CYC - 1);
            else              refi_cnt <= refi_cnt - 1'b1;
            if (start_i)      pending <= pending - 1'b1;
            else if (add_one) pending <= pending + 1'b1;
          end
        end
      endcase
    end
  end

  assign want_o      = ((phase == PH_INIT) && (burst_left != '0)) ||
                       ((phase == PH_RUN) && (pending != '0));
  assign init_done_o = (phase == PH_RUN);
  assign phase_o     = phase;

  p_quiet_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (!want_o && !start_i));

  p_done_after_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> ($past(burst_left) == '0 && $past(cyc_idle_i)));

  p_postpone_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= QW'(MAX_POSTPONE));

  p_idle_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_o && long_idle_i) |=> (!init_done_o && want_o));
endmodule

// File: rtl/dref_strobe_gen.sv
module dref_strobe_gen
  import dref_pkg::*;
#(
  parameter int CAS_LEAD  = 2,
  parameter int RAS_CYC   = 8,
  parameter int PRE_CYC   = 5,
  parameter int CAS_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 want_i,
  input  logic                 grant_i,
  output logic                 start_o,
  output logic                 idle_o,
  output logic                 ras_rise_o,
  output logic                 ras_n_o,
  output logic [CAS_LANES-1:0] cas_n_o
);
  localparam int MX1 = (CAS_LEAD > RAS_CYC) ? CAS_LEAD : RAS_CYC;
  localparam int MXC = (MX1 > PRE_CYC) ? MX1 : PRE_CYC;
  localparam int CW  = $clog2(MXC + 1);

  dref_cyc_t     state;
  logic [CW-1:0] tcnt;
  logic          cas_low;
  logic          tdone;

  assign tdone   = (tcnt == '0);
  assign idle_o  = (state == CY_IDLE);
  assign start_o = idle_o && want_i && grant_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CY_IDLE;
      tcnt  <= '0;
    end else begin
      case (state)
        CY_IDLE: if (start_o) begin
          state <= CY_CAS;
          tcnt  <= CW'(CAS_LEAD - 1);
        end
        CY_CAS: if (tdone) begin
          state <= CY_RAS;
          tcnt  <= CW'(RAS_CYC - 1);
        end else tcnt <= tcnt - 1'b1;
        CY_RAS: if (tdone) begin
          state <= CY_PRE;
          tcnt  <= CW'(PRE_CYC - 1);
        end else tcnt <= tcnt - 1'b1;
        default: if (tdone) state <= CY_IDLE;
                 else       tcnt  <= tcnt - 1'b1;
      endcase
    end
  end

  assign cas_low    = (state == CY_CAS) || (state == CY_RAS);
  assign ras_n_o    = (state != CY_RAS);
  assign ras_rise_o = (state == CY_RAS) && tdone;

  for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
    assign cas_n_o[g] = !cas_low;
  end

  logic [CW:0] chk_low_len;
  logic [CW:0] chk_cas_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_low_len <= '0;
      chk_cas_len <= '0;
    end else begin
      chk_low_len <= ras_n_o ? '0 : chk_low_len + 1'b1;
      chk_cas_len <= (cas_n_o == '0 && ras_n_o) ? chk_cas_len + 1'b1 : '0;
    end
  end

  p_ras_needs_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> (cas_n_o == '0));

  p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (chk_cas_len == (CW+1)'(CAS_LEAD)));

  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (chk_low_len == (CW+1)'(RAS_CYC)));

  p_start_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CY_CAS && $past(state) == CY_IDLE) |-> $past(grant_i));
endmodule

// File: rtl/dref_pulse_ctr.sv
module dref_pulse_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count_o <= '0;
    else if (pulse_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/dref_refresh_seq.sv
module dref_refresh_seq
  import dref_pkg::*;
#(
  parameter int PAUSE_CYC    = 62500,
  parameter int INIT_CYCLES  = 8,
  parameter int REFI_CYC     = 1950,
  parameter int CAS_LEAD     = 2,
  parameter int RAS_CYC      = 8,
  parameter int PRE_CYC      = 5,
  parameter int MAX_POSTPONE = 8,
  parameter int CAS_LANES    = 4,
  parameter int CNT_W        = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant_i,
  input  logic                 long_idle_i,
  output logic                 req_o,
  output logic                 ras_n_o,
  output logic [CAS_LANES-1:0] cas_n_o,
  output logic                 we_n_o,
  output logic                 init_done_o,
  output logic [CNT_W-1:0]     refresh_count_o
);
  logic        want;
  logic        start;
  logic        cyc_idle;
  logic        ras_rise;
  dref_phase_t phase;

  dref_pacer #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES),
    .REFI_CYC(REFI_CYC), .MAX_POSTPONE(MAX_POSTPONE)
  ) u_pacer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cyc_idle_i(cyc_idle),
    .long_idle_i(long_idle_i), .want_o(want), .init_done_o(init_done_o),
    .phase_o(phase)
  );

  dref_strobe_gen #(
    .CAS_LEAD(CAS_LEAD), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC),
    .CAS_LANES(CAS_LANES)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .want_i(want), .grant_i(grant_i),
    .start_o(start), .idle_o(cyc_idle), .ras_rise_o(ras_rise),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  dref_pulse_ctr #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .pulse_i(ras_rise), .count_o(refresh_count_o)
  );

  assign req_o  = want || !cyc_idle;
  assign we_n_o = 1'b1;

  p_pause_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |-> (ras_n_o && (&cas_n_o) && !req_o));

  p_strobes_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (ras_n_o && (&cas_n_o)));

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_o) |-> (refresh_count_o == CNT_W'($past(refresh_count_o) + 1'b1)));
endmodule

// File: tb/dref_refresh_seq_tb.sv
module dref_refresh_seq_tb;
  localparam int PAUSE = 200;
  localparam int INIT  = 8;
  localparam int REFI  = 100;
  localparam int LEAD  = 2;
  localparam int RASW  = 8;
  localparam int PRE   = 5;
  localparam int MAXP  = 4;
  localparam int LANES = 4;
  localparam int CW    = 16;
  localparam int BACK  = LEAD + RASW + PRE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic long_idle = 1'b0;
  logic req, ras_n, we_n, done;
  logic [LANES-1:0] cas_n;
  logic [CW-1:0] cnt;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  int falls = 0;
  int last_fall = 0;
  int last_gap = 0;
  int cas_run = 0;
  int ras_run = 0;
  int high_run = 0;
  bit seen_pulse = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dref_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .REFI_CYC(REFI), .CAS_LEAD(LEAD),
    .RAS_CYC(RASW), .PRE_CYC(PRE), .MAX_POSTPONE(MAXP), .CAS_LANES(LANES),
    .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .grant_i(grant), .long_idle_i(long_idle),
    .req_o(req), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .init_done_o(done), .refresh_count_o(cnt)
  );

  task automatic check(input string req_tag, input int actual, input int expected);
    vectors++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req_tag, actual, expected, cyc);
    end
  endtask

  // Continuous strobe monitor, sampled on falling edges
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (we_n !== 1'b1) check("R4 we_n high", int'(we_n), 1);
      if (!ras_n && cas_n != '0) check("R4 row low needs column low", int'(cas_n), 0);
      if (!ras_n && ras_run == 0) begin
        check("R4 column lead", cas_run, LEAD);
        if (seen_pulse) begin
          vectors++;
          if (high_run < PRE + LEAD + 1) begin
            errors++;
            $display("FAIL R5 precharge gap: actual %0d expected >= %0d", high_run, PRE + LEAD + 1);
          end
        end
        falls++;
        last_gap  = cyc - last_fall;
        last_fall = cyc;
      end
      if (ras_n && ras_run != 0) begin
        check("R5 row pulse width", ras_run, RASW);
        seen_pulse = 1;
      end
    end
    cas_run  = (cas_n == '0 && ras_n) ? cas_run + 1 : 0;
    ras_run  = !ras_n ? ras_run + 1 : 0;
    high_run = ras_n ? high_run + 1 : 0;
  end

  task automatic wait_falls(input int n);
    int target = falls + n;
    for (int i = 0; i < 5000 && falls < target; i++) @(negedge clk);
    if (falls < target) check("watchdog wait for row pulses", falls, target);
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    if (!done) check(tag, 0, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; grant = 1'b0; long_idle = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req", int'(req), 0);
    check("R1 ras_n", int'(ras_n), 1);
    check("R1 cas_n", int'(cas_n), (1 << LANES) - 1);
    check("R1 we_n", int'(we_n), 1);
    check("R1 init_done", int'(done), 0);
    check("R1 count", int'(cnt), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_pause();
    grant = 1'b1;  // grant offered early: must not matter during the pause
    repeat (PAUSE - 1) @(negedge clk);
    check("R2 req low in pause", int'(req), 0);
    check("R2 strobes high in pause", int'(ras_n), 1);
    check("R2 no pulses in pause", falls, 0);
    grant = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 req after pause", int'(req), 1);
    check("R7 no cycle without grant", int'(cas_n), (1 << LANES) - 1);
  endtask

  task automatic t_init();
    int f0 = falls;
    grant = 1'b1;
    wait_done("R3 init_done rises");
    check("R3 pulses before init_done", falls - f0, INIT);
    check("R10 count after init", int'(cnt), INIT);
  endtask

  task automatic t_periodic();
    wait_falls(2);
    wait_falls(1);
    check("R6 refresh spacing", last_gap, REFI);
    wait_falls(1);
    check("R6 refresh spacing again", last_gap, REFI);
    check("R3 init_done held", int'(done), 1);
  endtask

  task automatic t_postpone();
    int f0, c0;
    wait_falls(1);
    @(negedge clk);
    grant = 1'b0;   // mid-cycle: pulse must still complete
    f0 = falls;
    repeat (6 * REFI) @(negedge clk);
    check("R7 no pulses while grant low", falls - f0, 0);
    check("R7 req held for owed work", int'(req), 1);
    c0 = int'(cnt);
    f0 = falls;
    grant = 1'b1;
    repeat (80) @(negedge clk);
    check("R8 owed refreshes issued", falls - f0, MAXP);
    check("R8 back-to-back spacing", last_gap, BACK);
    check("R10 count step after catch-up", int'(cnt) - c0, MAXP);
  endtask

  task automatic t_long_idle();
    int f0, c0;
    wait_falls(1);
    @(negedge clk);
    f0 = falls;
    c0 = int'(cnt);
    long_idle = 1'b1;
    @(negedge clk);
    long_idle = 1'b0;
    check("R9 init_done dropped", int'(done), 0);
    wait_done("R9 init_done returns");
    check("R9 repeated burst size", falls - f0, INIT);
    check("R10 count after repeat", int'(cnt) - c0 - 1, INIT);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_pause();
    t_init();
    t_periodic();
    t_postpone();
    t_long_idle();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule